// File: doc/BRIEF.md
# Adaptive double-error-correcting BCH decoder

The block decodes 79-bit words that protect 64 data bits with a binary BCH code over GF(2^7), shortened to 78 positions and extended by one overall parity bit. It corrects any two bit errors and flags any three as uncorrectable. It computes the two odd syndromes and the overall parity of the received word combinationally. It then sorts the word into a class in the same cycle. Clean words, single-error words and detected triple errors leave through a one-cycle path. Only double-error words enter a second stage, which holds a scaled error-locator polynomial and tests all 78 positions in parallel.

The second stage's coefficient registers load only when a double-error word is accepted and hold their value otherwise. A stream of clean or single-error words therefore never toggles the locator-evaluation logic. While syndromes ripple, that logic sees only stable register outputs.

Top module: `bch_dec_adaptive`

## Requirements
- R1: Codeword layout: bits [13:0] are check bits, bits [77:14] carry data bit 0 to 63, and bit 78 makes the XOR of all 79 bits zero. With alpha a root of x^7+x^3+1, the check bits are chosen so that the XOR of alpha^i and the XOR of alpha^(3i) over all set bits i in 0..77 are both zero.
- R2: A word with no error gives data_o equal to bits [77:14] and status_o = 0, with done_o high in the first cycle after valid_i.
- R3: A word with one flipped bit, at any of the 79 positions, gives the original data and status_o = 1, with done_o in the first cycle after valid_i.
- R4: A word with two flipped bits gives the original data and status_o = 2. done_o stays low in the first cycle after valid_i and is high in the second.
- R5: A word with three flipped bits gives status_o = 3, with done_o in the first cycle after valid_i, and data_o carries the received data field unchanged.
- R6: After reset, done_o, status_o and data_o are zero. done_o goes high only for a word accepted one or two cycles earlier, and it is a one-cycle pulse for each word.
- R7: The locator coefficient registers load only when a double-error word is accepted and hold otherwise. Two double-error words on consecutive cycles both decode correctly, in order.
- R8: Two flips where one of them is the overall parity bit are decoded as a double error: status_o = 2, with the original data.
- R9: Words of the one-cycle classes may arrive on consecutive cycles, and each completes one cycle after its own valid_i. The cycle after a double-error word must be idle or carry another double-error word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | cw_i holds a word to decode this cycle |
| cw_i | input | 79 | Received codeword |
| done_o | output | 1 | Result valid pulse |
| status_o | output | 2 | 0 clean, 1 one fixed, 2 two fixed, 3 uncorrectable |
| data_o | output | 64 | Corrected data |

## Verification
Fixed vectors place flips at the edges of each region: the first and last check bit, the first and last data bit, and the overall parity bit. These show whether the syndrome columns and the locator positions line up with the layout. A random mix of zero to three flips on random data tells the four classes apart, both by status and by the cycle in which done_o arrives. Back-to-back single-cycle words and back-to-back double-error words show whether the two paths keep words separate and in order.

// File: rtl/bch_dec_pkg.sv
`timescale 1ns/1ps
package bch_dec_pkg;
  localparam int GF_M = 7;
  localparam logic [GF_M-1:0] GF_POLY = 7'h09;  // x^7 = x^3 + 1
  localparam int GF_ORD = (1 << GF_M) - 1;

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIX1  = 2'd1,
    ST_FIX2  = 2'd2,
    ST_FAIL  = 2'd3
  } dec_st_e;

  function automatic gf_t gf_xtime(gf_t a);
    return a[GF_M-1] ? ((a << 1) ^ GF_POLY) : (a << 1);
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc ^= sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic gf_t gf_cube(gf_t a);
    return gf_mul(gf_mul(a, a), a);
  endfunction

  function automatic gf_t alpha_pow(int unsigned k);
    gf_t r;
    r = gf_t'(1);
    for (int unsigned n = 0; n < (k % GF_ORD); n++) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/bch_syn.sv
`timescale 1ns/1ps
module bch_syn
  import bch_dec_pkg::*;
#(
  parameter int N_POS = 78
) (
  input  logic [N_POS:0] cw_i,
  output gf_t            s1_o,
  output gf_t            s3_o,
  output logic           par_o
);
  gf_t t1 [N_POS];
  gf_t t3 [N_POS];

  for (genvar i = 0; i < N_POS; i++) begin : g_col
    localparam gf_t A1 = alpha_pow(i);
    localparam gf_t A3 = alpha_pow(3 * i);
    assign t1[i] = cw_i[i] ? A1 : '0;
    assign t3[i] = cw_i[i] ? A3 : '0;
  end

  always_comb begin
    s1_o = '0;
    s3_o = '0;
    for (int i = 0; i < N_POS; i++) begin
      s1_o ^= t1[i];
      s3_o ^= t3[i];
    end
  end

  assign par_o = ^cw_i;
endmodule

// File: rtl/bch_fast.sv
`timescale 1ns/1ps
module bch_fast
  import bch_dec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  gf_t               s1_i,
  input  gf_t               s3_i,
  input  gf_t               s1c_i,
  input  logic              par_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              dbl_o,
  output dec_st_e           st_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int DATA_LO = 2 * GF_M;

  logic        s_zero, single;
  gf_t         s1_g;
  logic [DATA_W-1:0] flip;

  assign s_zero = (s1_i == '0) && (s3_i == '0);
  assign single = par_i && (s3_i == s1c_i);
  assign dbl_o  = !par_i && (s1_i != '0);

  // comparators only see a syndrome for single-error words
  assign s1_g = single ? s1_i : '0;

  for (genvar j = 0; j < DATA_W; j++) begin : g_loc
    localparam gf_t LOC = alpha_pow(j + DATA_LO);
    assign flip[j] = (s1_g == LOC);
  end

  assign data_o = data_i ^ flip;

  always_comb begin
    if (!par_i && s_zero) st_o = ST_CLEAN;
    else if (single)      st_o = ST_FIX1;
    else                  st_o = ST_FAIL;
  end
endmodule

// File: rtl/bch_dbl.sv
`timescale 1ns/1ps
module bch_dbl
  import bch_dec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int N_POS  = 78
) (
  input  gf_t               a_i,
  input  gf_t               b_i,
  input  gf_t               c_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ok_o
);
  localparam int DATA_LO = 2 * GF_M;

  logic [N_POS-1:0] root;

  // S1*X^2 + S1^2*X + (S3 + S1^3) = 0 at each error locator X
  for (genvar i = 0; i < N_POS; i++) begin : g_pos
    localparam gf_t X1 = alpha_pow(i);
    localparam gf_t X2 = alpha_pow(2 * i);
    assign root[i] = ((gf_mul(a_i, X2) ^ gf_mul(b_i, X1) ^ c_i) == '0);
  end

  assign data_o = data_i ^ root[DATA_LO +: DATA_W];
  assign ok_o   = |root;
endmodule

// File: rtl/bch_dec_adaptive.sv
`timescale 1ns/1ps
module bch_dec_adaptive
  import bch_dec_pkg::*;
#(
  parameter  int DATA_W = 64,
  localparam int N_POS  = DATA_W + 2 * GF_M,
  localparam int CW_W   = N_POS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CW_W-1:0]   cw_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int DATA_LO = 2 * GF_M;

  gf_t s1, s3, s1c;
  logic par;

  bch_syn #(.N_POS(N_POS)) u_syn (
    .cw_i (cw_i),
    .s1_o (s1),
    .s3_o (s3),
    .par_o(par)
  );

  assign s1c = gf_cube(s1);

  logic              dbl;
  dec_st_e           fast_st;
  logic [DATA_W-1:0] fast_data;

  bch_fast #(.DATA_W(DATA_W)) u_fast (
    .s1_i  (s1),
    .s3_i  (s3),
    .s1c_i (s1c),
    .par_i (par),
    .data_i(cw_i[DATA_LO +: DATA_W]),
    .dbl_o (dbl),
    .st_o  (fast_st),
    .data_o(fast_data)
  );

  logic              dbl_load, dbl_v_q;
  gf_t               coef_a_q, coef_b_q, coef_c_q;
  logic [DATA_W-1:0] dbl_raw_q;

  assign dbl_load = valid_i && dbl;

  // enable-held stage: locator logic sees no syndrome ripple
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_v_q   <= 1'b0;
      coef_a_q  <= '0;
      coef_b_q  <= '0;
      coef_c_q  <= '0;
      dbl_raw_q <= '0;
    end else begin
      dbl_v_q <= dbl_load;
      if (dbl_load) begin
        coef_a_q  <= s1;
        coef_b_q  <= gf_mul(s1, s1);
        coef_c_q  <= s3 ^ s1c;
        dbl_raw_q <= cw_i[DATA_LO +: DATA_W];
      end
    end
  end

  logic [DATA_W-1:0] dbl_data;
  logic              dbl_ok;

  bch_dbl #(.DATA_W(DATA_W), .N_POS(N_POS)) u_dbl (
    .a_i   (coef_a_q),
    .b_i   (coef_b_q),
    .c_i   (coef_c_q),
    .data_i(dbl_raw_q),
    .data_o(dbl_data),
    .ok_o  (dbl_ok)
  );

  logic              done_q;
  dec_st_e           st_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      st_q   <= ST_CLEAN;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (dbl_v_q) begin
        done_q <= 1'b1;
        st_q   <= dbl_ok ? ST_FIX2 : ST_FAIL;
        data_q <= dbl_ok ? dbl_data : dbl_raw_q;
      end else if (valid_i && !dbl) begin
        done_q <= 1'b1;
        st_q   <= fast_st;
        data_q <= fast_data;
      end
    end
  end

  assign done_o   = done_q;
  assign status_o = st_q;
  assign data_o   = data_q;
endmodule

// File: rtl/bch_dec_adaptive_chk.sv
`timescale 1ns/1ps
module bch_dec_adaptive_chk
  import bch_dec_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       dbl,
  input logic       dbl_load,
  input logic       dbl_v_q,
  input logic       done_o,
  input logic [1:0] status_o,
  input gf_t        coef_a_q,
  input gf_t        coef_b_q,
  input gf_t        coef_c_q
);
  AST_FAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dbl && !dbl_v_q) |=> done_o);  // R2

  AST_FAST_NOT_FIX2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dbl && !dbl_v_q) |=> (status_o != 2'd2));  // R3

  AST_DBL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_load && !dbl_v_q) |=> !done_o);  // R4

  AST_DBL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_load |-> ##2 (done_o && status_o[1]));  // R4

  AST_LOC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbl_load |=> $stable({coef_a_q, coef_b_q, coef_c_q}));  // R7

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_i) || $past(dbl_v_q)));  // R6
endmodule

bind bch_dec_adaptive bch_dec_adaptive_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .dbl     (dbl),
  .dbl_load(dbl_load),
  .dbl_v_q (dbl_v_q),
  .done_o  (done_o),
  .status_o(status_o),
  .coef_a_q(coef_a_q),
  .coef_b_q(coef_b_q),
  .coef_c_q(coef_c_q)
);

// File: tb/bch_dec_adaptive_tb.sv
`timescale 1ns/1ps
module bch_dec_adaptive_tb;
  localparam int DW = 64;
  localparam int NP = 78;
  localparam int CW = 79;
  localparam logic [7:0] NO = 8'hFF;

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  e0;
    logic [7:0]  e1;
    logic [7:0]  e2;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{64'h0123_4567_89AB_CDEF, NO,    NO,    NO   },
    '{64'hFFFF_FFFF_FFFF_FFFF, NO,    NO,    NO   },
    '{64'h0000_0000_0000_0000, NO,    NO,    NO   },
    '{64'hDEAD_BEEF_0BAD_F00D, 8'd0,  NO,    NO   },
    '{64'h5555_AAAA_5555_AAAA, 8'd13, NO,    NO   },
    '{64'h1357_9BDF_2468_ACE0, 8'd14, NO,    NO   },
    '{64'h8000_0000_0000_0001, 8'd77, NO,    NO   },
    '{64'h7777_3333_1111_0000, 8'd78, NO,    NO   },
    '{64'hC0FF_EE00_1234_5678, 8'd14, 8'd77, NO   },
    '{64'h0F0F_0F0F_F0F0_F0F0, 8'd0,  8'd13, NO   },
    '{64'hA5A5_5A5A_3C3C_C3C3, 8'd20, 8'd78, NO   },
    '{64'h0000_FFFF_0000_FFFF, 8'd5,  8'd50, NO   },
    '{64'h9999_6666_9999_6666, 8'd0,  8'd1,  8'd2 },
    '{64'h1111_2222_3333_4444, 8'd14, 8'd50, 8'd78},
    '{64'hFEDC_BA98_7654_3210, 8'd30, 8'd31, 8'd77},
    '{64'h2BAD_1DEA_7E57_CA5E, 8'd3,  8'd40, NO   }
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          valid_i;
  logic [CW-1:0] cw_i;
  logic          done_o;
  logic [1:0]    status_o;
  logic [DW-1:0] data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  bch_dec_adaptive u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .cw_i    (cw_i),
    .done_o  (done_o),
    .status_o(status_o),
    .data_o  (data_o)
  );

  logic [6:0]  ap  [127];
  logic [13:0] sol [14];

  function automatic logic [13:0] syn_of(input logic [NP-1:0] w);
    logic [6:0] a, b;
    a = '0;
    b = '0;
    for (int i = 0; i < NP; i++)
      if (w[i]) begin
        a ^= ap[i];
        b ^= ap[(3 * i) % 127];
      end
    return {b, a};
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [NP-1:0] w;
    logic [13:0]   t, c;
    w = {d, 14'b0};
    t = syn_of(w);
    c = '0;
    for (int k = 0; k < 14; k++) if (t[k]) c ^= sol[k];
    w[13:0] = c;
    return {^w, w};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // one word, then an idle cycle; lat 2 for double-error words
  task automatic run_word(input logic [CW-1:0] cw, input logic [DW-1:0] exp_d,
                          input logic [1:0] exp_st, input string req);
    @(negedge clk_i);
    cw_i    = cw;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    cw_i    = '0;
    if (exp_st == 2'd2) begin
      check(done_o == 1'b0, req, "done too early", 64'(done_o), 64'd0);
      @(negedge clk_i);
    end
    check(done_o == 1'b1, req, "done", 64'(done_o), 64'd1);
    check(status_o == exp_st, req, "status", 64'(status_o), 64'(exp_st));
    check(data_o == exp_d, req, "data", data_o, exp_d);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6", "done pulse", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [CW-1:0] cw, cw2;
    logic [DW-1:0] d, d2;
    int            cnt;
    string         req;
    int            p0, p1, p2;

    ap[0] = 7'd1;
    for (int k = 1; k < 127; k++)
      ap[k] = {ap[k-1][5:0], 1'b0} ^ (ap[k-1][6] ? 7'h09 : 7'h00);
    for (int c = 1; c < 16384; c++) begin
      logic [13:0] cv, v;
      cv = c[13:0];
      v  = syn_of({64'b0, cv});
      if ($countones(v) == 1)
        for (int k = 0; k < 14; k++) if (v[k]) sol[k] = cv;
    end

    rst_ni  = 1'b0;
    valid_i = 1'b0;
    cw_i    = '0;
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R6", "reset done", 64'(done_o), 64'd0);
    check(status_o == 2'd0, "R6", "reset status", 64'(status_o), 64'd0);
    check(data_o == '0, "R6", "reset data", data_o, 64'd0);
    rst_ni = 1'b1;

    // R1: bench-built codewords satisfy both syndromes and even parity
    cw = encode(64'hCAFE_F00D_DEAD_BEEF);
    check(syn_of(cw[NP-1:0]) == 14'd0 && !(^cw), "R1", "encoder", 64'(syn_of(cw[NP-1:0])), 64'd0);
    run_word(cw, 64'hCAFE_F00D_DEAD_BEEF, 2'd0, "R1");

    foreach (TBL[i]) begin
      cw  = encode(TBL[i].d);
      cnt = 0;
      if (TBL[i].e0 != NO) begin cw[TBL[i].e0] ^= 1'b1; cnt++; end
      if (TBL[i].e1 != NO) begin cw[TBL[i].e1] ^= 1'b1; cnt++; end
      if (TBL[i].e2 != NO) begin cw[TBL[i].e2] ^= 1'b1; cnt++; end
      case (cnt)
        0: req = "R2";
        1: req = "R3";
        2: req = (TBL[i].e1 == 8'd78) ? "R8" : "R4";
        default: req = "R5";
      endcase
      run_word(cw, (cnt == 3) ? cw[77:14] : TBL[i].d, 2'(cnt), req);
    end

    for (int r = 0; r < 150; r++) begin
      d   = {$urandom, $urandom};
      cw  = encode(d);
      cnt = $urandom_range(0, 3);
      p0  = $urandom_range(0, 78);
      p1  = p0;
      while (p1 == p0) p1 = $urandom_range(0, 78);
      p2  = p0;
      while (p2 == p0 || p2 == p1) p2 = $urandom_range(0, 78);
      if (cnt > 0) cw[p0] ^= 1'b1;
      if (cnt > 1) cw[p1] ^= 1'b1;
      if (cnt > 2) cw[p2] ^= 1'b1;
      case (cnt)
        0: run_word(cw, d, 2'd0, "R2");
        1: run_word(cw, d, 2'd1, "R3");
        2: run_word(cw, d, 2'd2, "R4");
        default: run_word(cw, cw[77:14], 2'd3, "R5");
      endcase
    end

    // R9: single-cycle words back to back
    d  = 64'h0102_0304_0506_0708;
    d2 = 64'hF0E0_D0C0_B0A0_9080;
    cw = encode(d);
    cw2 = encode(d2);
    cw2[33] ^= 1'b1;
    @(negedge clk_i);
    cw_i = cw; valid_i = 1'b1;
    @(negedge clk_i);
    cw_i = cw2;
    check(done_o && status_o == 2'd0, "R9", "first status", 64'(status_o), 64'd0);
    check(data_o == d, "R9", "first data", data_o, d);
    @(negedge clk_i);
    valid_i = 1'b0; cw_i = '0;
    check(done_o && status_o == 2'd1, "R9", "second status", 64'(status_o), 64'd1);
    check(data_o == d2, "R9", "second data", data_o, d2);
    @(negedge clk_i);
    check(done_o == 1'b0, "R9", "idle after pair", 64'(done_o), 64'd0);

    // R7: double-error words back to back
    d  = 64'h1234_0000_ABCD_FFFF;
    d2 = 64'h0000_5678_FFFF_9876;
    cw = encode(d);
    cw[2] ^= 1'b1; cw[60] ^= 1'b1;
    cw2 = encode(d2);
    cw2[15] ^= 1'b1; cw2[76] ^= 1'b1;
    @(negedge clk_i);
    cw_i = cw; valid_i = 1'b1;
    @(negedge clk_i);
    cw_i = cw2;
    check(done_o == 1'b0, "R7", "no early done", 64'(done_o), 64'd0);
    @(negedge clk_i);
    valid_i = 1'b0; cw_i = '0;
    check(done_o && status_o == 2'd2, "R7", "first status", 64'(status_o), 64'd2);
    check(data_o == d, "R7", "first data", data_o, d);
    @(negedge clk_i);
    check(done_o && status_o == 2'd2, "R7", "second status", 64'(status_o), 64'd2);
    check(data_o == d2, "R7", "second data", data_o, d2);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6", "idle after doubles", 64'(done_o), 64'd0);

    // R7: clean words after a double leave the next double intact
    run_word(encode(64'h5A5A_5A5A_5A5A_5A5A), 64'h5A5A_5A5A_5A5A_5A5A, 2'd0, "R7");
    cw = encode(64'h0BAD_CAFE_0000_0001);
    cw[14] ^= 1'b1; cw[15] ^= 1'b1;
    run_word(cw, 64'h0BAD_CAFE_0000_0001, 2'd2, "R7");

    finish_run();
  end
endmodule